// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is one timer channel. Software sets it up through three registers and a status location. The control word holds these fields: run enable, interrupt enable, a repeat-mode select, a restart strobe, a read-only running indicator and an 8-bit divide field. A second register holds the reload value. A third returns the live count and cannot be written. While the channel runs, it steps its count down once every (divide field + 1) pulses of a reference tick strobe. When a step ends the count, the channel sets a sticky status flag. In repeat mode it then reloads from the reload register and keeps going. In single-shot mode it stops.

The block is a two-state machine. In ST_IDLE the count is frozen. In ST_RUN the count steps. There are three transitions. ENABLE goes from ST_IDLE to ST_RUN when a control write sets the run bit and does not also set restart. DISABLE goes from ST_RUN to ST_IDLE when a control write leaves the run bit clear or sets restart. EXPIRE_ONCE goes from ST_RUN to ST_IDLE when the count ends in single-shot mode. Both the enable bit and the running indicator are read back from the state, so they always agree. The interrupt output is the status flag gated by interrupt enable.

Top module: `rtmr_channel`

## Requirements
- R1: After reset the control word reads 0x00000005 (divide field 5, everything else 0), the reload value and count read 0, status reads 0 and irq_o is low.
- R2: Control word fields: bit 30 run enable, bit 29 interrupt enable, bit 27 repeat mode, bit 26 restart (always reads 0), bit 25 running indicator (read-only), bits 7:0 divide field. Written values in bits 24:8 and bit 25 are discarded and read back as 0.
- R3: While running with divide field p, the count drops by one on every (p+1)-th tick. Tick counting restarts on ENABLE, on restart and on a reload write. A step is dropped in a cycle that writes the control word or the reload register.
- R4: When a step occurs at count 1 or 0, status is set. In single-shot mode the count becomes 0 and the channel stops, so bits 30 and 25 read 0.
- R5: In repeat mode, the step that ends the count loads the reload value and the channel keeps running.
- R6: A control write with restart set loads the count from the reload register and leaves the channel stopped, even if the same write sets the run bit.
- R7: A write to the reload register (select 1) loads the count with the written value at once, in either state.
- R8: DISABLE freezes the count and ENABLE resumes from the frozen value. A DISABLE write without restart that finds the count at 0 sets status.
- R9: irq_o equals interrupt enable AND status. Writing 1 to bit 0 at select 3 clears status, but a status set in the same cycle wins.
- R10: Writes to the count register (select 2) have no effect on the count.
- R11: Changing the divide field while running leaves the current count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Reference tick strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 control, 1 reload, 2 count, 3 status |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as wr_sel_i |
| rd_data_o | output | DATA_W | Read data (status in bit 0), combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same clock edge. One is the expiry step that sets status. The other is a software write that clears status. The bench times a status-clear write to land exactly on the edge where a repeat-mode count ends, and expects status to stay set with the count already reloaded. A second collision, a DISABLE write landing while the count is already 0, is judged by status being raised by the write alone.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
    localparam int PRE_W = 8;

    localparam int B_EN  = 30;
    localparam int B_IE  = 29;
    localparam int B_PER = 27;
    localparam int B_RST = 26;
    localparam int B_ACT = 25;

    localparam logic [PRE_W-1:0] PRESC_RESET = 8'd5;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_STAT  = 2'd3
    } sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic [PW-1:0] div_i,
    output logic          step_o
);
    logic [PW-1:0] pcnt_q;

    assign step_o = run_i && tick_i && (pcnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clear_i) begin
            pcnt_q <= '0;
        end else if (run_i && tick_i) begin
            if (pcnt_q >= div_i) pcnt_q <= '0;
            else                 pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtmr_flag.sv
module rtmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assign irq_o = flag_o && ie_i;
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import rtmr_pkg::*;

    state_e            st_q, st_d;
    logic [DATA_W-1:0] count_q, init_q;
    logic [PRE_W-1:0]  presc_q;
    logic              ie_q, per_q;
    logic              run, step, cnt_step;
    logic              ctl_wr, init_wr, stat_clr;
    logic              wr_rst, en_req;
    logic              expire, pause_zero, zero_evt;
    logic              pre_clear, status;

    assign run      = (st_q == ST_RUN);
    assign ctl_wr   = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign init_wr  = wr_en_i && (wr_sel_i == SEL_INIT);
    assign stat_clr = wr_en_i && (wr_sel_i == SEL_STAT) && wr_data_i[0];
    assign wr_rst   = wr_data_i[B_RST];
    assign en_req   = wr_data_i[B_EN] && !wr_rst;

    assign cnt_step   = step && !ctl_wr && !init_wr;
    assign expire     = run && cnt_step && (count_q <= 1);
    assign pause_zero = ctl_wr && run && !en_req && !wr_rst && (count_q == '0);
    assign zero_evt   = expire || pause_zero;
    assign pre_clear  = init_wr || (ctl_wr && wr_rst) || (ctl_wr && !run && en_req);

    rtmr_prescale #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i),
        .clear_i(pre_clear), .div_i(presc_q), .step_o(step)
    );

    rtmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(zero_evt), .clr_i(stat_clr),
        .ie_i(ie_q), .flag_o(status), .irq_o(irq_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (ctl_wr && en_req) st_d = ST_RUN;          // ENABLE
            ST_RUN: begin
                if (ctl_wr && !en_req)      st_d = ST_IDLE;        // DISABLE
                else if (expire && !per_q)  st_d = ST_IDLE;        // EXPIRE_ONCE
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Control fields and reload value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            per_q   <= 1'b0;
            presc_q <= PRESC_RESET;
            init_q  <= '0;
        end else begin
            if (ctl_wr) begin
                ie_q    <= wr_data_i[B_IE];
                per_q   <= wr_data_i[B_PER];
                presc_q <= wr_data_i[PRE_W-1:0];
            end
            if (init_wr) init_q <= wr_data_i;
        end
    end

    // Count
    always_ff @(posedge clk) begin
        if (!rst_n)                 count_q <= '0;
        else if (init_wr)           count_q <= wr_data_i;
        else if (ctl_wr && wr_rst)  count_q <= init_q;
        else if (expire)            count_q <= per_q ? init_q : '0;
        else if (run && cnt_step)   count_q <= count_q - 1'b1;
    end

    // Outputs: read mux
    always_comb begin
        rd_data_o = '0;
        unique case (rd_sel_i)
            SEL_CTRL: begin
                rd_data_o[B_EN]      = run;
                rd_data_o[B_IE]      = ie_q;
                rd_data_o[B_PER]     = per_q;
                rd_data_o[B_ACT]     = run;
                rd_data_o[PRE_W-1:0] = presc_q;
            end
            SEL_INIT:  rd_data_o = init_q;
            SEL_COUNT: rd_data_o = count_q;
            SEL_STAT:  rd_data_o[0] = status;
            default:   rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              run,
    input logic              step,
    input logic              per_q,
    input logic              status,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] init_q
);
    logic ctl_wr, init_wr, clr_wr;
    assign ctl_wr  = wr_en_i && (wr_sel_i == 2'd0);
    assign init_wr = wr_en_i && (wr_sel_i == 2'd1);
    assign clr_wr  = wr_en_i && (wr_sel_i == 2'd3) && wr_data_i[0];

    p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && step && !ctl_wr && !init_wr && (count_q > 1) |=> count_q == $past(count_q) - 1);

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && step && !ctl_wr && !init_wr && (count_q <= 1) && !per_q |=> !run && status && count_q == '0);

    p_restart_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && wr_data_i[26] |=> !run && count_q == $past(init_q));

    p_init_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> count_q == $past(wr_data_i));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !ctl_wr && !init_wr |=> $stable(count_q));

    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status && !clr_wr |=> status);
endmodule

bind rtmr_channel rtmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .run(run), .step(step), .per_q(per_q),
    .status(status), .count_q(count_q), .init_q(init_q)
);

// File: tb/rtmr_channel_bench.sv
module rtmr_channel_bench;
    localparam logic [31:0] EN  = 32'h4000_0000;
    localparam logic [31:0] IE  = 32'h2000_0000;
    localparam logic [31:0] PER = 32'h0800_0000;
    localparam logic [31:0] RST = 32'h0400_0000;
    localparam logic [31:0] ACT = 32'h0200_0000;

    typedef struct packed {
        logic [7:0]  p;
        logic [31:0] n;
        logic        per;
        logic [15:0] w;
        logic [31:0] exp_cnt;
        logic        exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{8'd0, 32'd5, 1'b0, 16'd3,  32'd2, 1'b0},
        '{8'd0, 32'd5, 1'b0, 16'd5,  32'd0, 1'b1},
        '{8'd0, 32'd5, 1'b0, 16'd9,  32'd0, 1'b1},
        '{8'd3, 32'd4, 1'b0, 16'd10, 32'd2, 1'b0},
        '{8'd3, 32'd4, 1'b0, 16'd16, 32'd0, 1'b1},
        '{8'd1, 32'd3, 1'b1, 16'd8,  32'd2, 1'b1},
        '{8'd1, 32'd3, 1'b1, 16'd6,  32'd3, 1'b1},
        '{8'd0, 32'd0, 1'b1, 16'd2,  32'd0, 1'b1},
        '{8'd2, 32'd6, 1'b1, 16'd9,  32'd3, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic [1:0]  rd_sel_i = 2'd0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtmr_channel u_rtmr_channel (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        rd_sel_i = sel;
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", req, sel, rd_data_o, exp);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq_o, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", 2'd0, 32'h0000_0005);
        chk("R1", 2'd1, 32'd0);
        chk("R1", 2'd2, 32'd0);
        chk("R1", 2'd3, 32'd0);
        chk_irq("R1", 1'b0);

        // R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {24'd0, TBL[i].p});
            wr(2'd1, TBL[i].n);
            wr(2'd3, 32'd1);
            wr(2'd0, EN | (TBL[i].per ? PER : 32'd0) | {24'd0, TBL[i].p});
            repeat (int'(TBL[i].w)) @(negedge clk);
            chk(TBL[i].per ? "R5" : "R3", 2'd2, TBL[i].exp_cnt);
            chk("R4", 2'd3, {31'd0, TBL[i].exp_st});
        end

        // R2 reserved bits and indicator discarded
        wr(2'd0, 32'h01FF_FF00 | ACT);
        chk("R2", 2'd0, 32'd0);

        // R4 single-shot clears enable and indicator
        wr(2'd1, 32'd2);
        wr(2'd3, 32'd1);
        wr(2'd0, EN | IE);
        chk("R2", 2'd0, EN | IE | ACT);
        repeat (3) @(negedge clk);
        chk("R4", 2'd0, IE);
        chk_irq("R9", 1'b1);
        wr(2'd3, 32'd1);
        chk_irq("R9", 1'b0);

        // R6 restart with enable stays stopped
        wr(2'd1, 32'd10);
        wr(2'd0, EN);
        repeat (3) @(negedge clk);
        chk("R3", 2'd2, 32'd7);
        wr(2'd0, EN | RST);
        chk("R6", 2'd0, 32'd0);
        chk("R6", 2'd2, 32'd10);
        repeat (3) @(negedge clk);
        chk("R6", 2'd2, 32'd10);

        // R8 pause and resume
        wr(2'd1, 32'd20);
        wr(2'd0, EN);
        repeat (4) @(negedge clk);
        wr(2'd0, 32'd0);
        chk("R8", 2'd2, 32'd16);
        repeat (5) @(negedge clk);
        chk("R8", 2'd2, 32'd16);
        wr(2'd0, EN);
        repeat (2) @(negedge clk);
        chk("R8", 2'd2, 32'd14);

        // R11 divide change keeps count, R7 reload while running
        wr(2'd1, 32'd100);
        wr(2'd0, EN | 32'd7);
        repeat (3) @(negedge clk);
        chk("R11", 2'd2, 32'd100);
        wr(2'd0, EN);
        chk("R11", 2'd2, 32'd100);
        @(negedge clk);
        chk("R11", 2'd2, 32'd99);
        wr(2'd1, 32'd50);
        chk("R7", 2'd2, 32'd50);
        wr(2'd0, 32'd0);
        chk("R8", 2'd2, 32'd50);

        // R10 count register write ignored
        wr(2'd2, 32'h0000_0123);
        chk("R10", 2'd2, 32'd50);

        // R8 disable at zero raises status; R9 gating by enable
        wr(2'd3, 32'd1);
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd0);
        wr(2'd3, 32'd1);
        wr(2'd0, EN | 32'd3);
        chk("R8", 2'd3, 32'd0);
        wr(2'd0, 32'd3);
        chk("R8", 2'd3, 32'd1);
        chk_irq("R9", 1'b0);
        wr(2'd0, IE | 32'd3);
        chk_irq("R9", 1'b1);
        wr(2'd3, 32'd1);
        chk_irq("R9", 1'b0);

        // R9 expiry and status clear on the same edge
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd4);
        wr(2'd3, 32'd1);
        wr(2'd0, EN | PER);
        repeat (3) @(negedge clk);
        wr(2'd3, 32'd1);
        chk("R9", 2'd3, 32'd1);
        chk("R5", 2'd2, 32'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule